// File: doc/BRIEF.md
# Control-Bit Majority Decoder

This block recovers four application control flags that arrive once per frame in a broadcast audio stream. A frame sequencer counts aligned frames in blocks of sixteen. A vote cell for each flag counts how many of those frames carried a one. When the block closes, each cell commits a decided value. Isolated bit errors therefore cannot change the flags that downstream logic sees.

The decided flags form a status field. The same flags also drive four output pins. A separate enable input gates the pins: when enable is low the pins are held low, and the status field is not affected. While frame alignment is lost, the partial block is discarded and the last decided flags are kept.

The sequencer has two states. In ST_UNLOCKED no frames are accepted and the counters stay cleared. In ST_COLLECT frames are accepted and tallied. The transition LOCK (ST_UNLOCKED to ST_COLLECT) happens on the first clock with the alignment flag high. The transition UNLOCK (ST_COLLECT to ST_UNLOCKED) happens on any clock with the alignment flag low.

Top module: `ctlbit_vote_filter`

## Requirements
- R1: During and just after reset, `flags` and `flag_pins` are all 0.
- R2: Each flag lane counts ones on its own, over blocks of 16 accepted frames. Lane i uses bit i of `raw_bits`. A frame is accepted when `frame_stb` is high, `align_ok` is high, and the sequencer is in ST_COLLECT.
- R3: At the close of a block, a lane whose count of ones is 9 or more sets its flag to 1.
- R4: At the close of a block, a lane whose count of ones is 7 or fewer sets its flag to 0.
- R5: At the close of a block, a lane whose count of ones is exactly 8 keeps its previous flag.
- R6: `flags` changes only on the clock edge that accepts the 16th frame of a block. The new value is visible from the next cycle on.
- R7: With `pin_en` = 1, `flag_pins` equals `flags`, with no added latency.
- R8: With `pin_en` = 0, `flag_pins` is all 0 and `flags` keeps working.
- R9: A clock with `align_ok` = 0 moves the sequencer to ST_UNLOCKED and clears the frame count and all tallies. `flags` keeps its value, and strobes during that time are not counted.
- R10: The strobe on the first clock with `align_ok` high again (the LOCK transition) is not counted. Counting starts from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| raw_bits | input | 4 | Raw control bits of the current frame, valid with `frame_stb` |
| align_ok | input | 1 | Frame alignment is valid |
| pin_en | input | 1 | Enables the output pins |
| flags | output | 4 | Decided flags (status field) |
| flag_pins | output | 4 | Gated flag pins |

## Verification
The assertions check, on every cycle, the rules that depend only on the current state: flags stay stable except on the accepted 16th frame, pins are low when disabled, tallies stay in range, and loss of alignment clears the frame count. Whether a decision is correct depends on the full sixteen-frame history. This includes the 9/7 thresholds, the tie-hold rule, the discarding of a partial block, and the strobe that is ignored on LOCK. Only the bench scenarios can show these, by comparing against a reference model.

// File: rtl/ctlbit_vote_pkg.sv
package ctlbit_vote_pkg;
    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_COLLECT  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/ctlbit_frame_seq.sv
module ctlbit_frame_seq
    import ctlbit_vote_pkg::*;
#(
    parameter int WIN = 16,
    localparam int FW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          align_ok,
    input  logic          frame_stb,
    output logic          take,
    output logic          last,
    output logic          clr,
    output logic [FW-1:0] frame_idx
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: if (align_ok)  state_d = ST_COLLECT;
            ST_COLLECT:  if (!align_ok) state_d = ST_UNLOCKED;
            default:     state_d = ST_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNLOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        take = 1'b0;
        clr  = 1'b0;
        unique case (state_q)
            ST_UNLOCKED: clr  = 1'b1;
            ST_COLLECT:  begin
                clr  = !align_ok;
                take = align_ok && frame_stb;
            end
            default:     clr  = 1'b1;
        endcase
        last = take && (frame_idx == FW'(WIN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    frame_idx <= '0;
        else if (clr)  frame_idx <= '0;
        else if (take) frame_idx <= last ? '0 : frame_idx + 1'b1;
    end
endmodule

// File: rtl/ctlbit_vote_cell.sv
module ctlbit_vote_cell #(
    parameter int WIN = 16,
    localparam int CW  = $clog2(WIN + 1),
    localparam int THR = WIN / 2 + 1,
    localparam int LOW = (WIN - 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          last,
    input  logic          clr,
    input  logic          bit_in,
    output logic [CW-1:0] tally,
    output logic          decided
);
    logic [CW-1:0] total;

    assign total = tally + CW'(bit_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally   <= '0;
            decided <= 1'b0;
        end else if (clr) begin
            tally   <= '0;
        end else if (take) begin
            if (last) begin
                tally <= '0;
                if (total >= CW'(THR))      decided <= 1'b1;
                else if (total <= CW'(LOW)) decided <= 1'b0;
            end else begin
                tally <= total;
            end
        end
    end
endmodule

// File: rtl/ctlbit_vote_filter.sv
module ctlbit_vote_filter #(
    parameter int NBITS = 4,
    parameter int WIN   = 16,
    localparam int CW   = $clog2(WIN + 1),
    localparam int FW   = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [NBITS-1:0] raw_bits,
    input  logic             align_ok,
    input  logic             pin_en,
    output logic [NBITS-1:0] flags,
    output logic [NBITS-1:0] flag_pins
);
    logic                take, last, clr;
    logic [FW-1:0]       frame_idx;
    logic [NBITS*CW-1:0] tallies;

    ctlbit_frame_seq #(.WIN(WIN)) u_seq (
        .clk(clk), .rst_n(rst_n), .align_ok(align_ok), .frame_stb(frame_stb),
        .take(take), .last(last), .clr(clr), .frame_idx(frame_idx)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_lane
        ctlbit_vote_cell #(.WIN(WIN)) u_cell (
            .clk(clk), .rst_n(rst_n), .take(take), .last(last), .clr(clr),
            .bit_in(raw_bits[i]), .tally(tallies[i*CW +: CW]),
            .decided(flags[i])
        );
    end

    always_comb begin
        flag_pins = '0;
        if (pin_en) flag_pins = flags;
    end
endmodule

// File: rtl/ctlbit_vote_chk.sv
module ctlbit_vote_chk #(
    parameter int NBITS = 4,
    parameter int WIN   = 16,
    localparam int CW   = $clog2(WIN + 1),
    localparam int FW   = $clog2(WIN)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_stb,
    input logic                align_ok,
    input logic                pin_en,
    input logic [NBITS-1:0]    flags,
    input logic [NBITS-1:0]    flag_pins,
    input logic [FW-1:0]       frame_idx,
    input logic [NBITS*CW-1:0] tallies
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (flags == '0 && flag_pins == '0));

    a_r6_hold_off_block: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_stb && align_ok && frame_idx == FW'(WIN - 1)) |=> $stable(flags));

    a_r8_pins_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> flag_pins == '0);

    a_r9_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !align_ok |=> (frame_idx == '0 && tallies == '0));

    for (genvar i = 0; i < NBITS; i++) begin : g_chk
        a_r2_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
            tallies[i*CW +: CW] <= CW'(WIN - 1));
    end
endmodule

bind ctlbit_vote_filter ctlbit_vote_chk #(.NBITS(NBITS), .WIN(WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .align_ok(align_ok),
    .pin_en(pin_en), .flags(flags), .flag_pins(flag_pins),
    .frame_idx(frame_idx), .tallies(tallies)
);

// File: tb/ctlbit_vote_filter_tb.sv
module ctlbit_vote_filter_tb;
    logic       clk = 0, rst_n = 0, frame_stb = 0, align_ok = 0, pin_en = 0;
    logic [3:0] raw_bits = '0, flags, flag_pins;
    int n_tests = 0, n_fail = 0;

    int         m_cnt [4];
    int         m_frame = 0;
    logic [3:0] m_flags = '0;

    always #2.5 clk = ~clk;

    ctlbit_vote_filter u_dut (.*);

    function automatic logic vote(int ones, logic prev);
        if (ones >= 9) return 1'b1;
        if (ones <= 7) return 1'b0;
        return prev;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_pins(string req);
        check(req, flag_pins, pin_en ? m_flags : 4'b0000);
    endtask

    task automatic model_clear();
        m_frame = 0;
        foreach (m_cnt[i]) m_cnt[i] = 0;
    endtask

    // one accepted frame, then a gap cycle; checks R6 / R2..R5
    task automatic send(logic [3:0] b);
        @(negedge clk); frame_stb = 1; raw_bits = b;
        @(negedge clk); frame_stb = 0; raw_bits = '0;
        foreach (m_cnt[i]) m_cnt[i] += b[i];
        m_frame++;
        if (m_frame == 16) begin
            foreach (m_cnt[i]) m_flags[i] = vote(m_cnt[i], m_flags[i]);
            model_clear();
            check("R2-R5 block decision", flags, m_flags);
        end else begin
            check("R6 stable mid-block", flags, m_flags);
        end
        check_pins("R7/R8 pins");
    endtask

    task automatic send_block(int k0, int k1, int k2, int k3);
        for (int f = 0; f < 16; f++)
            send({f < k3, f < k2, f < k1, f < k0});
    endtask

    task automatic lock();
        @(negedge clk); align_ok = 1;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 reset flags", flags, 4'b0000);
        check("R1 reset pins", flag_pins, 4'b0000);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", flags, 4'b0000);

        pin_en = 1;
        lock();
        // R3/R4 thresholds: 9->1, 7->0, 16->1, 0->0
        send_block(9, 7, 16, 0);
        check("R3 nine ones sets", {3'b0, flags[0]}, 4'b0001);
        check("R4 seven ones clears", {3'b0, flags[1]}, 4'b0000);
        // R5: tie holds; lanes 0,2 were 1, lanes 1,3 were 0
        send_block(8, 8, 8, 8);
        check("R5 tie keeps", flags, 4'b0101);
        send_block(15, 9, 8, 0);
        check("R2 independent lanes", flags, 4'b0111);

        // R8: disabled pins low while flags still work
        pin_en = 0;
        send_block(0, 0, 16, 16);
        check("R8 pins low", flag_pins, 4'b0000);
        check("R8 flags update", flags, 4'b1100);
        pin_en = 1;
        @(negedge clk);
        check("R7 pins follow", flag_pins, 4'b1100);

        // R9: partial block dropped on unlock, flags retained
        for (int f = 0; f < 10; f++) send(4'b0011);
        @(negedge clk); align_ok = 0;
        model_clear();
        @(negedge clk); frame_stb = 1; raw_bits = 4'b1111;
        @(negedge clk); frame_stb = 0;
        check("R9 flags retained", flags, 4'b1100);
        // R10: strobe on LOCK cycle ignored
        @(negedge clk); align_ok = 1; frame_stb = 1; raw_bits = 4'b1111;
        @(negedge clk); frame_stb = 0; raw_bits = '0;
        send_block(9, 9, 7, 7);
        check("R9 R10 fresh block", flags, 4'b0011);

        // random blocks, random pin enable, occasional unlock
        for (int blk = 0; blk < 40; blk++) begin
            for (int f = 0; f < 16; f++) begin
                pin_en = $urandom_range(0, 3) != 0;
                send(4'($urandom));
                if ($urandom_range(0, 99) == 0) begin
                    @(negedge clk); align_ok = 0; model_clear();
                    @(negedge clk);
                    check("R9 random unlock", flags, m_flags);
                    lock();
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule